// File: doc/BRIEF.md
# Grouped Input Numeric Decoder

This block collects eight bits from a bank of conditioned digital inputs and reads them as one 8-bit number. An index map chooses the input behind each bit. The number can be read in one of three ways: as a pair of decimal digits, as a one-hot position code, or as plain binary. The decoded value and an error flag go into an output register. That register keeps its contents until the next decode.

The stage before this one pulses `start` when its inputs are settled. On the following cycle this block raises `done` for one cycle, and the new result is readable from that cycle on. While `irq_en` is high, an interrupt pulse goes out together with `done`.

Top module: `grp_num_decoder`

## Requirements
- R1: While reset is active and right after it, `result` is 0 and `err`, `done` and `irq` are low.
- R2: `done` is high for exactly one cycle, the cycle after the one in which `start` is sampled high. It is low at all other times.
- R3: Bit b of the decoded word (bit 0 is the least significant) is taken from `din[k]`. Here k is the unsigned field `idx_map[3b+2:3b]`.
- R4: With `fmt` = 0 (decimal digits), the upper nibble is the tens digit and the lower nibble is the ones digit. `result` = tens*10 + ones and `err` = 0.
- R5: With `fmt` = 0, if either nibble is above 9, `err` = 1 and `result` = 0.
- R6: With `fmt` = 1 (one-hot), exactly one word bit is set. `result` is the position 0..7 of that bit and `err` = 0.
- R7: With `fmt` = 1, if no bit is set or more than one bit is set, `err` = 1 and `result` = 0.
- R8: With `fmt` = 2 (binary), `result` equals the word and `err` = 0.
- R9: `fmt` = 3 is reserved. It gives `err` = 1 and `result` = 0.
- R10: `result` and `err` change only on the cycle after a `start`. Changes on `din`, `idx_map` or `fmt` without a `start` have no effect on them.
- R11: `irq` pulses together with `done` only if `irq_en` was high when `start` was sampled. Otherwise `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Decode request from the previous stage |
| din | input | N_IN | Conditioned digital inputs |
| idx_map | input | 8*IW | One 3-bit input index per word bit |
| fmt | input | 2 | Interpretation: 0 decimal, 1 one-hot, 2 binary, 3 reserved |
| irq_en | input | 1 | Allows the interrupt pulse |
| result | output | 8 | Decoded value |
| err | output | 1 | Code was not legal for the chosen format |
| done | output | 1 | One-cycle pulse: new result is valid |
| irq | output | 1 | Interrupt pulse that comes with done |

## Verification
The state inside this block is the result register and the done/irq flags, so any fault in it reaches the ports at once. A wrong decode appears in `result` or `err` on the `done` cycle, one cycle after `start`. A faulty hold path is caught when `result` moves while only `din` is changing, at the first edge after that change. A done or interrupt flag that fires too early, too late or without a request is exposed on the cycle after `start`. Illegal codes sit next to legal ones: 99 against A3 for the digits, and single against zero or double bits for one-hot. This catches comparison limits that are off by one.

// File: rtl/grp_num_decoder.sv
module grp_num_decoder #(
  parameter int N_IN = 8,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [N_IN-1:0] din,
  input  logic [8*IW-1:0] idx_map,
  input  logic [1:0]      fmt,
  input  logic            irq_en,
  output logic [7:0]      result,
  output logic            err,
  output logic            done,
  output logic            irq
);

  logic [7:0] word;
  logic [3:0] hi, lo;
  logic [2:0] oh_pos;
  logic [3:0] oh_cnt;
  logic [7:0] nxt_val;
  logic       nxt_err;

  always_comb begin
    for (int b = 0; b < 8; b++)
      word[b] = din[idx_map[b*IW +: IW]];
  end

  assign hi = word[7:4];
  assign lo = word[3:0];

  always_comb begin
    oh_pos = '0;
    oh_cnt = '0;
    for (int b = 0; b < 8; b++) begin
      if (word[b]) begin
        oh_pos = 3'(b);
        oh_cnt = oh_cnt + 4'd1;
      end
    end
  end

  always_comb begin
    nxt_val = '0;
    nxt_err = 1'b0;
    unique case (fmt)
      2'd0: begin
        if (hi > 4'd9 || lo > 4'd9) nxt_err = 1'b1;
        else nxt_val = 8'({hi, 3'b000}) + 8'({hi, 1'b0}) + 8'(lo);
      end
      2'd1: begin
        if (oh_cnt != 4'd1) nxt_err = 1'b1;
        else nxt_val = 8'(oh_pos);
      end
      2'd2: nxt_val = word;
      default: nxt_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      err    <= 1'b0;
      done   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      done <= start;
      irq  <= start & irq_en;
      if (start) begin
        result <= nxt_val;
        err    <= nxt_err;
      end
    end
  end

endmodule

// File: rtl/grp_num_decoder_chk.sv
module grp_num_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] fmt,
  input logic       irq_en,
  input logic [7:0] result,
  input logic       err,
  input logic       done,
  input logic       irq
);

  p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  p_no_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  p_bin_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && fmt == 2'd2) |=> !err);

  p_rsv_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && fmt == 2'd3) |=> (err && result == 8'd0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(err)));

  p_irq_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !irq_en) |=> !irq);

  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (!done && !irq);
    end
  end

endmodule

bind grp_num_decoder grp_num_decoder_chk u_chk (.*);

// File: tb/tb_grp_num_decoder.sv
module tb_grp_num_decoder;

  localparam int N_IN = 8;
  localparam int IW = 3;

  typedef struct packed {
    logic [7:0] r;
    logic       e;
    logic       i;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [N_IN-1:0] din = '0;
  logic [8*IW-1:0] idx_map = '0;
  logic [1:0]      fmt = '0;
  logic            irq_en = 1'b0;
  logic [7:0]      result;
  logic            err, done, irq;

  int   n_chk = 0;
  int   n_fail = 0;
  exp_t expq[$];
  string tagq[$];
  logic [8*IW-1:0] map_id, map_rev, map_dup;

  always #4 clk = ~clk;

  grp_num_decoder #(.N_IN(N_IN)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din), .idx_map(idx_map),
    .fmt(fmt), .irq_en(irq_en), .result(result), .err(err), .done(done), .irq(irq)
  );

  function automatic exp_t model(input logic [7:0] d, input logic [8*IW-1:0] m,
                                 input logic [1:0] f, input logic en);
    exp_t x;
    logic [7:0] w;
    int cnt, pos;
    for (int b = 0; b < 8; b++) w[b] = d[int'(m[b*IW +: IW])];
    x.r = 8'd0; x.e = 1'b0; x.i = en;
    case (f)
      2'd0: if (int'(w[7:4]) > 9 || int'(w[3:0]) > 9) x.e = 1'b1;
            else x.r = 8'(int'(w[7:4]) * 10 + int'(w[3:0]));
      2'd1: begin
        cnt = 0; pos = 0;
        for (int b = 0; b < 8; b++) if (w[b]) begin cnt++; pos = b; end
        if (cnt != 1) x.e = 1'b1; else x.r = 8'(pos);
      end
      2'd2: x.r = w;
      default: x.e = 1'b1;
    endcase
    return x;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [7:0] d, input logic [8*IW-1:0] m,
                     input logic [1:0] f, input logic en);
    @(negedge clk);
    din = d; idx_map = m; fmt = f; irq_en = en;
    expq.push_back(model(d, m, f, en));
    tagq.push_back(tag);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 done after start", done === 1'b1, 32'(done), 32'd1);
    @(negedge clk);
    check("R2 done single cycle", done === 1'b0, 32'(done), 32'd0);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) begin
        check("R2 unexpected done", 1'b0, 32'd1, 32'd0);
      end else begin
        exp_t x;
        string t;
        x = expq.pop_front();
        t = tagq.pop_front();
        check(t, result === x.r && err === x.e, {23'd0, result, err}, {23'd0, x.r, x.e});
        check("R11 irq", irq === x.i, 32'(irq), 32'(x.i));
      end
    end
  end

  initial begin
    #(200000 * 8);
    check("watchdog", 1'b0, 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    for (int b = 0; b < 8; b++) begin
      map_id[b*IW +: IW]  = 3'(b);
      map_rev[b*IW +: IW] = 3'(7 - b);
      map_dup[b*IW +: IW] = 3'd0;
    end
    repeat (3) @(negedge clk);
    check("R1 reset outputs", result === 8'd0 && err === 1'b0 && done === 1'b0 && irq === 1'b0,
          {22'd0, result, err, done, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", result === 8'd0 && !done && !irq, {24'd0, result}, 32'd0);

    run("R4 digits 47", 8'h47, map_id, 2'd0, 1'b1);
    run("R4 digits 99", 8'h99, map_id, 2'd0, 1'b1);
    run("R5 digit ones 15", 8'h3F, map_id, 2'd0, 1'b1);
    run("R5 digit tens 10", 8'hA3, map_id, 2'd0, 1'b1);
    run("R6 onehot bit5", 8'h20, map_id, 2'd1, 1'b1);
    run("R6 onehot bit0", 8'h01, map_id, 2'd1, 1'b1);
    run("R6 onehot bit7", 8'h80, map_id, 2'd1, 1'b1);
    run("R7 onehot none", 8'h00, map_id, 2'd1, 1'b1);
    run("R7 onehot two", 8'h18, map_id, 2'd1, 1'b1);
    run("R8 binary C5", 8'hC5, map_id, 2'd2, 1'b1);
    run("R9 reserved", 8'h12, map_id, 2'd3, 1'b1);
    run("R3 reversed map", 8'h01, map_rev, 2'd2, 1'b1);
    run("R3 reversed digits", 8'h21, map_rev, 2'd0, 1'b0);
    run("R3 duplicated input", 8'h01, map_dup, 2'd2, 1'b0);
    run("R11 irq disabled", 8'h55, map_id, 2'd2, 1'b0);

    run("R10 base", 8'h37, map_id, 2'd2, 1'b1);
    held = 8'h37;
    din = 8'hFF; fmt = 2'd3; idx_map = map_rev;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10 result held", result === held && err === 1'b0 && !done,
            {23'd0, result, err}, {23'd0, held, 1'b0});
      din = din - 8'd17;
    end

    for (int k = 0; k < 20; k++)
      run("R8 binary sweep", 8'(k * 13), map_id, 2'd2, 1'(k % 2));

    repeat (3) @(negedge clk);
    check("R2 queue drained", expq.size() == 0, 32'(expq.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule